// File: doc/BRIEF.md
# Rotating-Priority Tree Grant Selector

This block picks one winner among four request lines and changes the priority order on every clock cycle, so that a requester that keeps asking cannot shut out the others forever. It is built as a small binary tree of two-input selection cells. Each leaf cell watches a pair of request lines. The top cell decides which pair is served. Each cell passes an "anything pending" flag upward. The cell above grants a child by driving that child's enable.

A free-running counter drives the cells' select inputs and is also visible on an output. Every cell on one tree level shares one counter bit: the leaves use the low bit and the top cell uses the high bit. The grant is purely combinational from the present counter value, the requests and the enable, so a change on the request lines shows on the grant in the same cycle. A caller uses the grant directly and can read the count to know which order was in force.

Top module: `rot_tree_grant`

## Requirements
- R1: A high synchronous reset forces count to 0 at the next rising edge and keeps it there while reset stays high.
- R2: With reset low, count rises by one on every rising clock edge and goes from 3 back to 0.
- R3: While en is low, grant is 4'b0000 whatever the requests.
- R4: Grant never has more than one bit set. When en is high and at least one request bit is set, exactly one grant bit is set.
- R5: A grant bit is only set where the matching request bit is set.
- R6: In each two-input cell, select value 1 gives input 1 the priority and select value 0 gives input 0 the priority. A cell whose inputs are not both asserted grants the one that is asserted.
- R7: The top cell chooses between the upper pair req[3:2] (its input 1) and the lower pair req[1:0] (its input 0) using count bit 1. Both leaf cells use count bit 0. So for count c, the winner is the first set bit in the order req[0^c], req[1^c], req[2^c], req[3^c].
- R8: The grant has no register of its own. A request change made in the middle of a cycle shows on grant in that same cycle, with count unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| req | input | 4 | Request lines, one per requester |
| en | input | 1 | Permits any grant when high |
| grant | output | 4 | One-hot or zero grant |
| count | output | 2 | Rotation counter that sets the current priority order |

## Verification
The main stimulus walks all sixteen request patterns across all four counter values. This separates a correct per-level select mapping from one with swapped bits or an inverted select, because each of those produces a different winner order for some count. All-ones requests show the top of each rotation. Single-bit requests show that a lone requester wins under every order. Enable-low bursts with every request set show the gating. A reset issued in the middle of the run, followed by a long run, tests the clearing and the wrap from 3 to 0. A request change in the middle of a cycle tells a combinational grant apart from one that waits for a clock edge.

// File: rtl/rtg_pkg.sv
package rtg_pkg;

  // Counter step with natural wrap at the width of the argument.
  function automatic logic [1:0] step2(input logic [1:0] c);
    return c + 2'd1;
  endfunction

  // Two-input selection: sel=1 favours input 1, sel=0 favours input 0.
  function automatic logic [1:0] pick2(input logic [1:0] r,
                                       input logic       en,
                                       input logic       sel);
    logic [1:0] g;
    g = 2'b00;
    if (en) begin
      if (sel) begin
        if (r[1])      g = 2'b10;
        else if (r[0]) g = 2'b01;
      end else begin
        if (r[0])      g = 2'b01;
        else if (r[1]) g = 2'b10;
      end
    end
    return g;
  endfunction

endpackage

// File: rtl/rtg_cell.sv
module rtg_cell
  import rtg_pkg::*;
(
  input  logic [1:0] req2,
  input  logic       en,
  input  logic       sel,
  output logic [1:0] gnt,
  output logic       up
);

  // The pending flag ignores enable so the parent can arbitrate first.
  assign up  = |req2;
  assign gnt = pick2(req2, en, sel);

endmodule

// File: rtl/rtg_counter.sv
module rtg_counter #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst,
  output logic [W-1:0] cnt
);

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_next;

  assign cnt_next = cnt_q + W'(1);

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_next;
  end

  assign cnt = cnt_q;

  // R1: reset clears the counter
  a_r1_reset_clears: assert property (@(posedge clk) rst |=> cnt_q == '0);

  // R2: one step per edge with wrap
  a_r2_step: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> cnt_q == W'($past(cnt_q) + W'(1)));

endmodule

// File: rtl/rtg_tree.sv
module rtg_tree #(
  parameter int LEVELS = 2,
  localparam int NREQ  = 1 << LEVELS
) (
  input  logic [NREQ-1:0]   req,
  input  logic              en,
  input  logic [LEVELS-1:0] sel,
  output logic [NREQ-1:0]   gnt,
  output logic              any_req
);

  // Heap numbering: node 1 is the root, child 2n covers the lower half
  // (input 0), child 2n+1 the upper half (input 1).
  logic up_n [1:NREQ-1];
  logic en_n [1:NREQ-1];

  assign en_n[1] = en;
  assign any_req = up_n[1];

  for (genvar n = 1; n < NREQ; n++) begin : g_node
    localparam int DEPTH = $clog2(n + 1) - 1;
    logic [1:0] kid_req;
    logic [1:0] kid_gnt;
    logic       kid_up;

    if (2 * n >= NREQ) begin : g_leaf
      localparam int J = n - NREQ / 2;
      assign kid_req            = req[2*J+1 -: 2];
      assign gnt[2*J+1 -: 2]    = kid_gnt;
    end else begin : g_inner
      assign kid_req     = {up_n[2*n+1], up_n[2*n]};
      assign en_n[2*n]   = kid_gnt[0];
      assign en_n[2*n+1] = kid_gnt[1];
    end

    assign up_n[n] = kid_up;

    // Each depth takes its own counter bit; the root takes the top bit.
    rtg_cell u_cell (
      .req2 (kid_req),
      .en   (en_n[n]),
      .sel  (sel[LEVELS-1-DEPTH]),
      .gnt  (kid_gnt),
      .up   (kid_up)
    );
  end

endmodule

// File: rtl/rot_tree_grant.sv
module rot_tree_grant #(
  parameter int LEVELS = 2,
  localparam int NREQ  = 1 << LEVELS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NREQ-1:0]   req,
  input  logic              en,
  output logic [NREQ-1:0]   grant,
  output logic [LEVELS-1:0] count
);

  logic [LEVELS-1:0] cnt_w;
  logic              tree_any;

  rtg_counter #(.W(LEVELS)) u_cnt (
    .clk (clk),
    .rst (rst),
    .cnt (cnt_w)
  );

  rtg_tree #(.LEVELS(LEVELS)) u_tree (
    .req     (req),
    .en      (en),
    .sel     (cnt_w),
    .gnt     (grant),
    .any_req (tree_any)
  );

  assign count = cnt_w;

  // R3: no grant while disabled
  a_r3_idle: assert property (@(posedge clk) disable iff (rst)
    !en |-> grant == '0);

  // R4: at most one grant
  a_r4_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant));

  // R4: some grant whenever enabled and the tree reports a request
  a_r4_live: assert property (@(posedge clk) disable iff (rst)
    (en && tree_any) |-> $countones(grant) == 1);

  // R5: grants only to requesters
  a_r5_granted_req: assert property (@(posedge clk) disable iff (rst)
    (grant & ~req) == '0);

  // R7: top level favours the upper half when the top count bit is set
  a_r7_top_upper: assert property (@(posedge clk) disable iff (rst)
    (en && count[LEVELS-1] && |req[NREQ-1:NREQ/2]) |-> grant[NREQ/2-1:0] == '0);

endmodule

// File: tb/tb_rot_tree_grant.sv
`timescale 1ns/1ps
module tb_rot_tree_grant;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] req = 4'b0;
  logic       en  = 1'b0;
  logic [3:0] grant;
  logic [1:0] count;

  int n_checks = 0;
  int n_errors = 0;
  bit done     = 1'b0;

  always #4 clk = ~clk;

  rot_tree_grant dut (
    .clk   (clk),
    .rst   (rst),
    .req   (req),
    .en    (en),
    .grant (grant),
    .count (count)
  );

  typedef struct {
    logic [3:0] g;
    logic [1:0] c;
    string      tag;
  } item_t;

  item_t sbq[$];
  logic [1:0] mcnt = 2'd0;

  // Model of the counter: cleared by reset, +1 per edge otherwise.
  always @(posedge clk) mcnt <= rst ? 2'd0 : mcnt + 2'd1;

  // Scan order for count c: req[i^c] for i = 0..3.
  function automatic logic [3:0] model(input logic [3:0] r, input logic e,
                                       input logic [1:0] c);
    logic [3:0] g;
    g = 4'b0;
    if (e) begin
      for (int i = 0; i < 4; i++) begin
        int k;
        k = i ^ int'(c);
        if (g == 4'b0 && r[k]) g[k] = 1'b1;
      end
    end
    return g;
  endfunction

  task automatic check(input string tag, input logic [5:0] act,
                       input logic [5:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
    end
  endtask

  // Driver: applies one cycle of stimulus and queues the expectation.
  task automatic drive(input logic [3:0] r, input logic e, input string tag);
    item_t it;
    @(negedge clk);
    req = r;
    en  = e;
    it.c   = mcnt;
    it.g   = model(r, e, mcnt);
    it.tag = tag;
    sbq.push_back(it);
  endtask

  // Monitor: compares results 2 ns after the inputs changed.
  always @(negedge clk) begin
    #2;
    if (sbq.size() > 0) begin
      item_t it;
      it = sbq.pop_front();
      check(it.tag, {count, grant}, {it.c, it.g});
      check(rst ? "R1 count under reset" : "R2 count step",
            {4'b0, count}, {4'b0, it.c});
      check("R4 one-hot", {5'b0, $countones(grant) <= 1}, 6'b1);
    end
  end

  initial begin
    #(8 * 20000);
    n_errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    // Reset state: count 0, grant for order 0,1,2,3
    repeat (3) @(negedge clk);
    drive(4'b0000, 1'b0, "R1 reset idle");
    drive(4'b1111, 1'b1, "R1 reset count0 order");
    drive(4'b1010, 1'b1, "R1 reset count0 order");
    @(negedge clk); rst = 1'b0;

    // All request patterns over all count values
    for (int k = 0; k < 64; k++) drive(4'(k >> 2), 1'b1, "R7 pattern sweep");
    // All-ones shows the head of each rotation
    for (int k = 0; k < 8; k++) drive(4'b1111, 1'b1, "R6 all requests");
    // Lone requesters win under every order
    for (int b = 0; b < 4; b++)
      for (int k = 0; k < 4; k++) drive(4'(1 << b), 1'b1, "R5 single request");
    // Pairs inside one leaf and across leaves
    for (int k = 0; k < 4; k++) drive(4'b0011, 1'b1, "R6 leaf pair");
    for (int k = 0; k < 4; k++) drive(4'b0110, 1'b1, "R7 cross pair");
    // Disabled
    for (int k = 0; k < 6; k++) drive(4'b1111, 1'b0, "R3 enable low");
    drive(4'b0000, 1'b1, "R4 no request");

    // Reset in mid-run
    @(negedge clk); rst = 1'b1;
    drive(4'b1100, 1'b1, "R1 mid reset");
    drive(4'b1100, 1'b1, "R1 mid reset");
    @(negedge clk); rst = 1'b0;
    for (int k = 0; k < 10; k++) drive(4'b1001, 1'b1, "R2 wrap run");

    // Combinational grant: change requests within one cycle
    wait (sbq.size() == 0);
    @(negedge clk);
    req = 4'b0001; en = 1'b1;
    #1;
    check("R8 first half", {2'b0, grant}, {2'b0, model(4'b0001, 1'b1, mcnt)});
    req = 4'b1000;
    #1;
    check("R8 same cycle update", {count, grant}, {mcnt, model(4'b1000, 1'b1, mcnt)});
    repeat (2) @(negedge clk);
    #3;

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule